// File: doc/BRIEF.md
# Result Broadcast Bus Arbiter

This block lets three physical producers share one result broadcast bus. The producers are the load data buffer group, the adder and the multiply/divide unit. Each producer hands over a finished result as a producer tag and a data word. The arbiter grants one held result per cycle and drives it onto the bus as a single beat. That beat carries a valid bit, the 4-bit tag and the data to every consumer at once. The tag space holds eleven logical producers: six buffers, three adder stations and two multiply/divide stations. Tag 0 is reserved and means "no producer".

Each producer port is a valid/ready stream feeding a one-entry holding slot. A producer must keep valid, tag and data stable until it sees ready in the same cycle. Ready is high when the slot is empty, or when the slot is being drained onto the bus in that cycle. The operation latencies are 2 cycles for add, 3 for multiply and 12 for divide, so completions collide often. A result that loses arbitration waits in its slot. Meanwhile its port applies back-pressure.

The bus side has no back-pressure: a broadcast beat is valid for exactly one cycle. Grants rotate round-robin among the slots that hold a result.

Top module: `resbus_arbiter`

## Requirements
- R1: While reset is asserted, bus_valid, bus_tag and bus_data are all 0 and every in_ready bit is 1.
- R2: A result accepted at a rising edge (in_valid and in_ready both high) and granted at once appears on the bus right after the next rising edge, with its tag and data unchanged.
- R3: At most one holding slot is drained per cycle, so at most one port that already holds a result sees in_ready high.
- R4: Grant priority is round-robin over ports 0 (buffers), 1 (adder) and 2 (multiply/divide). After port i is granted, the search order is i+1, i+2, i (mod 3). After reset, port 0 comes first.
- R5: A held result that is not granted stays in its slot with the same tag and data, and its port's in_ready is low.
- R6: in_ready of a port is high exactly when its slot is empty or its slot is granted in that cycle. A new result can be accepted in the same cycle that the old one leaves.
- R7: When bus_valid is low, bus_tag and bus_data are both 0.
- R8: Each port only carries tags in its own range: port 0 tags 1..6, port 1 tags 7..9, port 2 tags 10..11. A result with a tag outside its port's range (including tag 0) is accepted and then dropped. It is never broadcast.
- R9: The bus never shows a valid beat with tag 0.
- R10: Every accepted in-range result is broadcast exactly once, and results from one port appear in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 3 | Per-port result valid (bit 0 buffers, 1 adder, 2 multiply/divide) |
| in_ready | output | 3 | Per-port ready; a result transfers when valid and ready are both high |
| in_tag | input | 12 | Per-port producer tag, port i in bits [4i+3:4i] |
| in_data | input | 96 | Per-port result data, port i in bits [32i+31:32i] |
| bus_valid | output | 1 | Broadcast beat valid |
| bus_tag | output | 4 | Broadcast producer tag |
| bus_data | output | 32 | Broadcast result data |

## Verification
The hard case is an arbitration round in which a slot is drained and refilled in the same cycle while the other two slots stay held. Only then can the ready rule, the priority pointer and per-port ordering all go wrong at once. The random phase keeps each port valid about half the time and makes producers hold their offers under back-pressure, so all three slots fill together over many cycles and refills line up with grants. Directed phases load all three ports in one cycle to fix the rotation order, and they present out-of-range and zero tags to show that these are dropped.

// File: rtl/resbus_pkg.sv
package resbus_pkg;
  localparam int RB_PORTS  = 3;
  localparam int RB_TAG_W  = 4;
  localparam int RB_DATA_W = 32;
  // per-port tag windows, port 0 in the low nibble
  localparam logic [RB_PORTS*RB_TAG_W-1:0] RB_TAG_LO = {4'd10, 4'd7, 4'd1};
  localparam logic [RB_PORTS*RB_TAG_W-1:0] RB_TAG_HI = {4'd11, 4'd9, 4'd6};
endpackage

// File: rtl/rb_hold_slot.sv
module rb_hold_slot #(
  parameter int TW = 4,
  parameter int DW = 32,
  parameter logic [TW-1:0] LO = 1,
  parameter logic [TW-1:0] HI = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [TW-1:0] in_tag,
  input  logic [DW-1:0] in_data,
  input  logic          drain,
  output logic          in_ready,
  output logic          full,
  output logic [TW-1:0] tag,
  output logic [DW-1:0] data
);
  logic accept;
  logic keep;

  assign in_ready = !full || drain;
  assign accept   = in_valid && in_ready;
  assign keep     = (in_tag != '0) && (in_tag >= LO) && (in_tag <= HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      tag  <= '0;
      data <= '0;
    end else if (accept && keep) begin
      full <= 1'b1;
      tag  <= in_tag;
      data <= in_data;
    end else if (drain) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/rb_rr_pick.sv
module rb_rr_pick #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] win_idx;
  logic [PW-1:0] nxt_idx;

  always_comb begin
    grant   = '0;
    any     = 1'b0;
    win_idx = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!any && req[idx]) begin
        any        = 1'b1;
        grant[idx] = 1'b1;
        win_idx    = PW'(idx);
      end
    end
    nxt_idx = (int'(win_idx) == N - 1) ? '0 : win_idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (any) ptr <= nxt_idx;
  end
endmodule

// File: rtl/resbus_arbiter.sv
module resbus_arbiter
  import resbus_pkg::*;
#(
  parameter int N  = RB_PORTS,
  parameter int TW = RB_TAG_W,
  parameter int DW = RB_DATA_W,
  parameter logic [N*TW-1:0] TAG_LO = RB_TAG_LO,
  parameter logic [N*TW-1:0] TAG_HI = RB_TAG_HI
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    in_valid,
  output logic [N-1:0]    in_ready,
  input  logic [N*TW-1:0] in_tag,
  input  logic [N*DW-1:0] in_data,
  output logic            bus_valid,
  output logic [TW-1:0]   bus_tag,
  output logic [DW-1:0]   bus_data
);
  logic [N-1:0]    slot_full;
  logic [N*TW-1:0] slot_tag;
  logic [N*DW-1:0] slot_data;
  logic [N-1:0]    grant;
  logic            any_grant;
  logic [TW-1:0]   sel_tag;
  logic [DW-1:0]   sel_data;

  for (genvar i = 0; i < N; i++) begin : g_slot
    rb_hold_slot #(
      .TW(TW), .DW(DW),
      .LO(TAG_LO[i*TW +: TW]),
      .HI(TAG_HI[i*TW +: TW])
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid[i]),
      .in_tag   (in_tag[i*TW +: TW]),
      .in_data  (in_data[i*DW +: DW]),
      .drain    (grant[i]),
      .in_ready (in_ready[i]),
      .full     (slot_full[i]),
      .tag      (slot_tag[i*TW +: TW]),
      .data     (slot_data[i*DW +: DW])
    );
  end

  rb_rr_pick #(.N(N)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (slot_full),
    .grant (grant),
    .any   (any_grant)
  );

  always_comb begin
    sel_tag  = '0;
    sel_data = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) begin
        sel_tag  = sel_tag  | slot_tag[i*TW +: TW];
        sel_data = sel_data | slot_data[i*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_tag   <= '0;
      bus_data  <= '0;
    end else begin
      bus_valid <= any_grant;
      bus_tag   <= any_grant ? sel_tag  : '0;
      bus_data  <= any_grant ? sel_data : '0;
    end
  end
endmodule

// File: rtl/resbus_arbiter_chk.sv
module resbus_arbiter_chk #(
  parameter int N  = 3,
  parameter int TW = 4,
  parameter int DW = 32,
  parameter logic [N*TW-1:0] TAG_LO = '0,
  parameter logic [N*TW-1:0] TAG_HI = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_valid,
  input logic [TW-1:0]   bus_tag,
  input logic [DW-1:0]   bus_data,
  input logic [N-1:0]    grant,
  input logic [N-1:0]    slot_full,
  input logic [N*TW-1:0] slot_tag
);
  logic tag_in_some_range;
  always_comb begin
    tag_in_some_range = 1'b0;
    for (int i = 0; i < N; i++)
      if (bus_tag >= TAG_LO[i*TW +: TW] && bus_tag <= TAG_HI[i*TW +: TW])
        tag_in_some_range = 1'b1;
  end

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (bus_tag == '0 && bus_data == '0));

  // R9
  no_tag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_tag != '0);

  // R8
  tag_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> tag_in_some_range);

  // R3
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3
  grant_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~slot_full) == '0);

  for (genvar i = 0; i < N; i++) begin : g_hold
    // R5
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_full[i] && !grant[i]) |=> (slot_full[i] && $stable(slot_tag[i*TW +: TW])));
  end
endmodule

bind resbus_arbiter resbus_arbiter_chk #(
  .N(N), .TW(TW), .DW(DW), .TAG_LO(TAG_LO), .TAG_HI(TAG_HI)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_tag   (bus_tag),
  .bus_data  (bus_data),
  .grant     (grant),
  .slot_full (slot_full),
  .slot_tag  (slot_tag)
);

// File: tb/resbus_arbiter_bench.sv
module resbus_arbiter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  in_valid;
  logic [2:0]  in_ready;
  logic [11:0] in_tag;
  logic [95:0] in_data;
  logic        bus_valid;
  logic [3:0]  bus_tag;
  logic [31:0] bus_data;

  logic        b_valid [3];
  logic [3:0]  b_tag   [3];
  logic [31:0] b_data  [3];

  // model state
  bit          m_full [3];
  logic [3:0]  m_tag  [3];
  logic [31:0] m_data [3];
  int          m_ptr;
  logic        e_valid;
  logic [3:0]  e_tag;
  logic [31:0] e_data;
  bit          last_rdy [3];

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    in_valid = {b_valid[2], b_valid[1], b_valid[0]};
    in_tag   = {b_tag[2], b_tag[1], b_tag[0]};
    in_data  = {b_data[2], b_data[1], b_data[0]};
  end

  resbus_arbiter u_resbus_arbiter (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_data(in_data),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data)
  );

  function automatic bit in_rng(int p, logic [3:0] t);
    case (p)
      0: return t >= 4'd1  && t <= 4'd6;
      1: return t >= 4'd7  && t <= 4'd9;
      default: return t >= 4'd10 && t <= 4'd11;
    endcase
  endfunction

  task automatic check_bus(string lbl);
    nvec++;
    if (bus_valid !== e_valid || bus_tag !== e_tag || bus_data !== e_data) begin
      nfail++;
      $display("FAIL %s bus got v=%0b tag=%0d data=%h exp v=%0b tag=%0d data=%h",
               lbl, bus_valid, bus_tag, bus_data, e_valid, e_tag, e_data);
    end
  endtask

  // called at a negedge with inputs already set; advances one clock
  task automatic tick();
    int  win;
    bit  rdy [3];
    logic [2:0] exp_rdy;
    #1;
    win = -1;
    for (int k = 0; k < 3; k++) begin
      int idx;
      idx = (m_ptr + k) % 3;
      if (win < 0 && m_full[idx]) win = idx;
    end
    for (int i = 0; i < 3; i++) rdy[i] = !m_full[i] || (win == i);
    exp_rdy = {rdy[2], rdy[1], rdy[0]};
    nvec++;
    if (in_ready !== exp_rdy) begin
      nfail++;
      $display("FAIL R3 R5 R6 in_ready got %b exp %b", in_ready, exp_rdy);
    end
    if (win >= 0) begin
      e_valid = 1'b1; e_tag = m_tag[win]; e_data = m_data[win];
      m_full[win] = 0;
      m_ptr = (win + 1) % 3;
    end else begin
      e_valid = 1'b0; e_tag = '0; e_data = '0;
    end
    for (int i = 0; i < 3; i++) begin
      if (b_valid[i] && rdy[i] && in_rng(i, b_tag[i])) begin
        m_full[i] = 1; m_tag[i] = b_tag[i]; m_data[i] = b_data[i];
      end
      last_rdy[i] = rdy[i];
    end
    @(negedge clk);
    if (e_valid) check_bus("R2 R4 R9 R10");
    else         check_bus("R7");
  endtask

  task automatic expect_tag(string lbl, logic ev, logic [3:0] et);
    nvec++;
    if (bus_valid !== ev || bus_tag !== et) begin
      nfail++;
      $display("FAIL %s bus got v=%0b tag=%0d exp v=%0b tag=%0d", lbl, bus_valid, bus_tag, ev, et);
    end
  endtask

  task automatic clear_inputs();
    for (int i = 0; i < 3; i++) begin b_valid[i] = 0; b_tag[i] = '0; b_data[i] = '0; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    clear_inputs();
    for (int i = 0; i < 3; i++) begin m_full[i] = 0; m_tag[i] = '0; m_data[i] = '0; last_rdy[i] = 1; end
    m_ptr = 0; e_valid = 0; e_tag = '0; e_data = '0;
    rst_n = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      nvec++;
      if (bus_valid !== 1'b0 || bus_tag !== 4'd0 || bus_data !== 32'd0 || in_ready !== 3'b111) begin
        nfail++;
        $display("FAIL R1 reset got v=%0b tag=%0d data=%h rdy=%b exp 0 0 0 111",
                 bus_valid, bus_tag, bus_data, in_ready);
      end
    end
    rst_n = 1'b1;

    // R4: all three at once, pointer at port 0 -> order 0,1,2
    b_valid[0] = 1; b_tag[0] = 4'd3;  b_data[0] = 32'hA0A0_0003;
    b_valid[1] = 1; b_tag[1] = 4'd8;  b_data[1] = 32'hB1B1_0008;
    b_valid[2] = 1; b_tag[2] = 4'd11; b_data[2] = 32'hC2C2_000B;
    tick();
    clear_inputs();
    tick(); expect_tag("R4", 1'b1, 4'd3);
    tick(); expect_tag("R4", 1'b1, 4'd8);
    tick(); expect_tag("R4", 1'b1, 4'd11);
    tick(); expect_tag("R7", 1'b0, 4'd0);

    // R4: pointer back at port 0; ports 2 and 0 together -> 0 first
    b_valid[2] = 1; b_tag[2] = 4'd10; b_data[2] = 32'h0000_0A0A;
    b_valid[0] = 1; b_tag[0] = 4'd6;  b_data[0] = 32'h0000_0606;
    tick();
    clear_inputs();
    tick(); expect_tag("R4", 1'b1, 4'd6);
    tick(); expect_tag("R4", 1'b1, 4'd10);
    tick();

    // R8: out-of-range and zero tags are taken and dropped
    b_valid[0] = 1; b_tag[0] = 4'd0;  b_data[0] = 32'hDEAD_0000;
    b_valid[1] = 1; b_tag[1] = 4'd2;  b_data[1] = 32'hDEAD_0002;
    b_valid[2] = 1; b_tag[2] = 4'd15; b_data[2] = 32'hDEAD_000F;
    tick();
    clear_inputs();
    tick(); expect_tag("R8", 1'b0, 4'd0);
    tick(); expect_tag("R8", 1'b0, 4'd0);
    nvec++;
    if (in_ready !== 3'b111) begin
      nfail++;
      $display("FAIL R8 in_ready got %b exp 111", in_ready);
    end

    // random phase with held offers under back-pressure
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < 3; i++) begin
        if (!(b_valid[i] && !last_rdy[i])) begin
          b_valid[i] = ($urandom % 2) == 0;
          if (($urandom % 8) == 0) b_tag[i] = 4'($urandom % 16);
          else case (i)
            0: b_tag[i] = 4'(1 + $urandom % 6);
            1: b_tag[i] = 4'(7 + $urandom % 3);
            default: b_tag[i] = 4'(10 + $urandom % 2);
          endcase
          b_data[i] = $urandom;
        end
      end
      tick();
    end
    clear_inputs();
    for (int c = 0; c < 4; c++) tick();
    finish_run();
  end
endmodule